// File: doc/BRIEF.md
# Floppy Head Positioning Sequencer

This block is the host-facing register file and the head-movement engine of a floppy disk controller. A host reaches four byte-wide registers through a 2-bit address, a chip select and separate read and write strobes. The host writes a command byte, and the block then moves the drive head with step pulses and a direction level. A synchronised track-zero input tells the block when the head has reached the outer edge. There is no interrupt output, so the host learns that a command has finished by polling the busy flag in the status register.

Two commands exist. Restore moves the head outward until track zero is seen, then clears the track register. Seek takes its destination from the data register and its starting point from the track register. It steps toward the destination and updates the track register by one on every pulse. The two low bits of the command byte choose the gap between pulses. Sector data transfer, disk encoding and motor timing are outside this block.

Top module: `fdc_head_seq`

## Requirements
- R1: With cs and wr high, a write to address 1 loads the track register, address 2 loads the sector register and address 3 loads the data register, all while idle. With cs and rd high, a read returns the status byte at address 0 and the addressed register at addresses 1 to 3. When cs and rd are not both high, rdata is 0.
- R2: Status bit 0 (busy) is 1 from the clock edge that accepts a command until that command completes, then returns to 0.
- R3: Command byte 0x00 to 0x03 (upper nibble 0) is restore. The block issues outward step pulses until the synchronised track-zero input is high at a decision point, then sets the track register to 0. If track zero is already high at the start, no pulse is issued.
- R4: Command byte 0x10 to 0x13 (upper nibble 1) is seek. The target is the data register and the starting point is the track register. Each pulse moves the track register one step toward the target. The command ends with the track register equal to the target, after exactly |target - track| pulses.
- R5: dir is 1 for inward pulses (track increasing) and 0 for outward pulses. dir does not change while step is high.
- R6: Each step pulse is high for exactly 4 clocks. Between consecutive pulses of one command, rising edges are 5 + (rate+1)*8 clocks apart, where rate is command bits [1:0].
- R7: If restore has issued 255 outward pulses and track zero is still low, the block sets status bit 4 (seek error), clears busy and leaves the track register unchanged. Bit 4 is cleared by the next accepted command.
- R8: While busy, host writes to the track, sector and data registers have no effect, and a command write is not accepted.
- R9: Status bit 2 equals the synchronised track-zero input while idle and reads 0 while busy. Status bits 1, 3 and 7:5 always read 0.
- R10: A command byte whose upper nibble is neither 0 nor 1 is not accepted. Busy stays 0 and no step pulse is issued.
- R11: After reset, the track, sector and data registers and the status byte read 0, and step and dir are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Chip select for host accesses |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe, one cycle per write |
| addr | input | 2 | Register address: 0 command/status, 1 track, 2 sector, 3 data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from the address |
| trk0 | input | 1 | Track-zero indication from the drive, asynchronous |
| step | output | 1 | Step pulse toward the drive |
| dir | output | 1 | Step direction, 1 inward and 0 outward |

## Verification
Some properties are checked on every cycle: the exact 4-clock pulse width, a steady direction level while a pulse is high, no pulse outside a busy command, a track register that only the host can move while idle, and a track register that moves by at most one per cycle while busy. Other behaviour needs the bench's scenarios with a behavioural drive model that follows the head position. These cover the number of pulses per seek, the final track value, the rate-dependent pulse spacing, the 255-pulse restore limit with its error flag, and the host writes that are dropped while busy.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam logic [1:0] ADR_CMD_STAT = 2'd0;
  localparam logic [1:0] ADR_TRACK    = 2'd1;
  localparam logic [1:0] ADR_SECTOR   = 2'd2;
  localparam logic [1:0] ADR_DATA     = 2'd3;

  localparam logic [3:0] OP_HOME = 4'h0;
  localparam logic [3:0] OP_GOTO = 4'h1;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_TRK0_BIT = 2;
  localparam int ST_SERR_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DECIDE = 2'd1,
    SQ_MOVE  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_REST  = 2'd0,
    PH_PULSE = 2'd1,
    PH_GAP   = 2'd2
  } pulse_phase_t;

  typedef enum logic {
    MODE_HOME = 1'b0,
    MODE_GOTO = 1'b1
  } move_mode_t;
endpackage

// File: rtl/fdc_regs.sv
module fdc_regs #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    addr,
  input  logic [TW-1:0] wdata,
  input  logic          busy,
  input  logic          trk_inc,
  input  logic          trk_dec,
  input  logic          trk_clr,
  output logic [TW-1:0] track_q,
  output logic [TW-1:0] sector_q,
  output logic [TW-1:0] data_q
);
  import fdc_pkg::*;

  logic          wr_ok;
  logic          trk_en, sec_en, dat_en;
  logic [TW-1:0] track_d;

  assign wr_ok  = host_wr && !busy;
  assign sec_en = wr_ok && (addr == ADR_SECTOR);
  assign dat_en = wr_ok && (addr == ADR_DATA);

  always_comb begin
    trk_en  = 1'b0;
    track_d = track_q;
    if (trk_clr) begin
      trk_en  = 1'b1;
      track_d = '0;
    end else if (trk_inc) begin
      trk_en  = 1'b1;
      track_d = track_q + 1'b1;
    end else if (trk_dec) begin
      trk_en  = 1'b1;
      track_d = track_q - 1'b1;
    end else if (wr_ok && (addr == ADR_TRACK)) begin
      trk_en  = 1'b1;
      track_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_q <= '0;
    end else if (trk_en) begin
      track_q <= track_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q <= '0;
    end else if (sec_en) begin
      sector_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (dat_en) begin
      data_q <= wdata;
    end
  end
endmodule

// File: rtl/fdc_step_gen.sv
module fdc_step_gen #(
  parameter int PULSE_W  = 4,
  parameter int GAP_UNIT = 8,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              step,
  output logic              done
);
  import fdc_pkg::*;

  localparam int MAX_GAP = GAP_UNIT * (2 ** RATE_W);
  localparam int MAX_LEN = (MAX_GAP > PULSE_W) ? MAX_GAP : PULSE_W;
  localparam int CW      = $clog2(MAX_LEN + 1);

  pulse_phase_t  phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] gap_len;
  logic          cnt_zero;

  assign gap_len  = CW'((32'(rate) + 1) * GAP_UNIT);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    unique case (phase_q)
      PH_REST: begin
        if (start) begin
          phase_d = PH_PULSE;
          cnt_d   = CW'(PULSE_W - 1);
        end
      end
      PH_PULSE: begin
        if (cnt_zero) begin
          phase_d = PH_GAP;
          cnt_d   = gap_len - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_GAP: begin
        if (cnt_zero) begin
          phase_d = PH_REST;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_REST;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign step = (phase_q == PH_PULSE);
endmodule

// File: rtl/fdc_seq.sv
module fdc_seq #(
  parameter int TW          = 8,
  parameter int RATE_W      = 2,
  parameter int RESTORE_MAX = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [TW-1:0]     wdata,
  input  logic [TW-1:0]     track,
  input  logic [TW-1:0]     target,
  input  logic              trk0_s,
  input  logic              move_done,
  output logic              busy,
  output logic              serr,
  output logic              dir,
  output logic              start,
  output logic [RATE_W-1:0] rate,
  output logic              trk_inc,
  output logic              trk_dec,
  output logic              trk_clr
);
  import fdc_pkg::*;

  localparam int SCW = $clog2(RESTORE_MAX + 1);

  seq_state_t        state_q, state_d;
  move_mode_t        mode_q, mode_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [SCW-1:0]    nstep_q, nstep_d;
  logic              serr_q, serr_d;
  logic              dir_q, dir_d;
  logic [3:0]        op;
  logic              op_ok;

  assign op    = wdata[7:4];
  assign op_ok = (op == OP_HOME) || (op == OP_GOTO);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rate_d  = rate_q;
    nstep_d = nstep_q;
    serr_d  = serr_q;
    dir_d   = dir_q;
    start   = 1'b0;
    trk_inc = 1'b0;
    trk_dec = 1'b0;
    trk_clr = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (cmd_wr && op_ok) begin
          state_d = SQ_DECIDE;
          mode_d  = (op == OP_GOTO) ? MODE_GOTO : MODE_HOME;
          rate_d  = wdata[RATE_W-1:0];
          nstep_d = '0;
          serr_d  = 1'b0;
        end
      end
      SQ_DECIDE: begin
        if (mode_q == MODE_HOME) begin
          if (trk0_s) begin
            trk_clr = 1'b1;
            state_d = SQ_IDLE;
          end else if (nstep_q == SCW'(RESTORE_MAX)) begin
            serr_d  = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            start   = 1'b1;
            dir_d   = 1'b0;
            nstep_d = nstep_q + 1'b1;
            state_d = SQ_MOVE;
          end
        end else begin
          if (track == target) begin
            state_d = SQ_IDLE;
          end else begin
            start   = 1'b1;
            dir_d   = (target > track);
            trk_inc = (target > track);
            trk_dec = (target < track);
            state_d = SQ_MOVE;
          end
        end
      end
      SQ_MOVE: begin
        if (move_done) begin
          state_d = SQ_DECIDE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= MODE_HOME;
      rate_q  <= '0;
      nstep_q <= '0;
      serr_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      rate_q  <= rate_d;
      nstep_q <= nstep_d;
      serr_q  <= serr_d;
      dir_q   <= dir_d;
    end
  end

  assign busy = (state_q != SQ_IDLE);
  assign serr = serr_q;
  assign dir  = dir_q;
  assign rate = rate_q;
endmodule

// File: rtl/fdc_head_seq.sv
module fdc_head_seq #(
  parameter int TW          = 8,
  parameter int PULSE_W     = 4,
  parameter int GAP_UNIT    = 8,
  parameter int RATE_W      = 2,
  parameter int RESTORE_MAX = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  input  logic          trk0,
  output logic          step,
  output logic          dir
);
  import fdc_pkg::*;

  logic              rst_meta_n, rst_sync_n;
  logic              trk0_meta, trk0_s;
  logic              host_wr, cmd_wr, trk_wr;
  logic              busy, serr, start, move_done;
  logic              trk_inc, trk_dec, trk_clr;
  logic [RATE_W-1:0] rate;
  logic [TW-1:0]     track_q, sector_q, data_q;
  logic [TW-1:0]     status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trk0_meta <= 1'b0;
      trk0_s    <= 1'b0;
    end else begin
      trk0_meta <= trk0;
      trk0_s    <= trk0_meta;
    end
  end

  assign host_wr = cs && wr;
  assign cmd_wr  = host_wr && (addr == ADR_CMD_STAT);
  assign trk_wr  = host_wr && (addr == ADR_TRACK);

  fdc_regs #(.TW(TW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .host_wr  (host_wr),
    .addr     (addr),
    .wdata    (wdata),
    .busy     (busy),
    .trk_inc  (trk_inc),
    .trk_dec  (trk_dec),
    .trk_clr  (trk_clr),
    .track_q  (track_q),
    .sector_q (sector_q),
    .data_q   (data_q)
  );

  fdc_seq #(
    .TW          (TW),
    .RATE_W      (RATE_W),
    .RESTORE_MAX (RESTORE_MAX)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_wr    (cmd_wr),
    .wdata     (wdata),
    .track     (track_q),
    .target    (data_q),
    .trk0_s    (trk0_s),
    .move_done (move_done),
    .busy      (busy),
    .serr      (serr),
    .dir       (dir),
    .start     (start),
    .rate      (rate),
    .trk_inc   (trk_inc),
    .trk_dec   (trk_dec),
    .trk_clr   (trk_clr)
  );

  fdc_step_gen #(
    .PULSE_W  (PULSE_W),
    .GAP_UNIT (GAP_UNIT),
    .RATE_W   (RATE_W)
  ) u_step (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .rate  (rate),
    .step  (step),
    .done  (move_done)
  );

  always_comb begin
    status              = '0;
    status[ST_BUSY_BIT] = busy;
    status[ST_TRK0_BIT] = trk0_s && !busy;
    status[ST_SERR_BIT] = serr;
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      unique case (addr)
        ADR_CMD_STAT: rdata = status;
        ADR_TRACK:    rdata = track_q;
        ADR_SECTOR:   rdata = sector_q;
        ADR_DATA:     rdata = data_q;
        default:      rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fdc_head_seq_chk.sv
module fdc_head_seq_chk #(
  parameter int TW      = 8,
  parameter int PULSE_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          dir,
  input logic          busy,
  input logic          host_trk_wr,
  input logic [TW-1:0] track
);
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (step) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step) |-> (hi_len == 8'(PULSE_W)));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= 8'(PULSE_W));

  // R5
  dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step)) |-> $stable(dir));

  // R2
  step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);

  // R8
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !host_trk_wr) |=> $stable(track));

  // R4
  track_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((track == $past(track)) || (track == $past(track) + 1'b1) ||
              (track == $past(track) - 1'b1) || (track == '0)));
endmodule

bind fdc_head_seq fdc_head_seq_chk #(.TW(TW), .PULSE_W(PULSE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .step        (step),
  .dir         (dir),
  .busy        (busy),
  .host_trk_wr (trk_wr),
  .track       (track_q)
);

// File: tb/fdc_head_seq_bench.sv
module fdc_head_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // each vector: target[23:16], rate[15:8], expected pulse count[7:0]
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd10, 8'd0, 8'd10},
    {8'd3,  8'd1, 8'd7},
    {8'd3,  8'd0, 8'd0},
    {8'd0,  8'd2, 8'd3},
    {8'd40, 8'd3, 8'd40},
    {8'd12, 8'd0, 8'd28}
  };

  logic       clk, rst_n, cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       step, dir, trk0;

  int  n_chk, n_bad;
  int  head_pos;
  bit  disc;
  int  pulses, last_period, last_width, cyc, last_rise, hi_run;
  bit  seen_rise, step_d, finished;
  logic [7:0] v;

  fdc_head_seq #(.PULSE_W(4), .GAP_UNIT(8)) u_fdc_head_seq (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trk0(trk0), .step(step), .dir(dir)
  );

  assign trk0 = (head_pos == 0) && !disc;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // drive model and pulse monitor
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (step && !step_d) begin
      pulses = pulses + 1;
      if (seen_rise) last_period = cyc - last_rise;
      last_rise = cyc;
      seen_rise = 1'b1;
      if (dir) head_pos = head_pos + 1;
      else if (head_pos > 0) head_pos = head_pos - 1;
    end
    if (step) hi_run = hi_run + 1;
    else if (step_d) begin
      last_width = hi_run;
      hi_run = 0;
    end
    step_d = step;
  end

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic clr_mon();
    pulses = 0; seen_rise = 1'b0; last_period = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd0, s);
      if (!s[0]) return;
    end
    chk(1, 0, "R2 busy never cleared");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    cyc = 0; hi_run = 0; step_d = 1'b0; last_width = 0;
    head_pos = 6; disc = 1'b0;
    clr_mon();
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      chk(v, 0, "R11 register after reset");
    end
    chk(step, 0, "R11 step after reset");
    chk(dir, 0, "R11 dir after reset");

    // R1 register readback
    wr_reg(2'd2, 8'h2A);
    rd_reg(2'd2, v); chk(v, 8'h2A, "R1 sector readback");
    wr_reg(2'd3, 8'h3C);
    rd_reg(2'd3, v); chk(v, 8'h3C, "R1 data readback");
    wr_reg(2'd1, 8'h21);
    rd_reg(2'd1, v); chk(v, 8'h21, "R1 track readback");
    @(negedge clk); #1 chk(rdata, 0, "R1 rdata without read strobe");

    // R3 restore from head position 6
    clr_mon();
    wr_reg(2'd0, 8'h00);
    wait_idle();
    chk(pulses, 6, "R3 restore pulse count");
    chk(head_pos, 0, "R3 head at track zero");
    rd_reg(2'd1, v); chk(v, 0, "R3 track cleared");
    rd_reg(2'd0, v); chk(v, 8'h04, "R9 idle status mirrors track zero");

    // R4 R5 R6 seek table
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] tgt, rt, ex;
      {tgt, rt, ex} = VEC[k];
      clr_mon();
      wr_reg(2'd3, tgt);
      wr_reg(2'd0, 8'h10 | rt);
      if (ex != 0) begin
        rd_reg(2'd0, v); chk(v[0], 1, "R2 busy during seek");
      end
      wait_idle();
      chk(pulses, ex, "R4 seek pulse count");
      rd_reg(2'd1, v); chk(v, tgt, "R4 track equals target");
      chk(head_pos, tgt, "R5 head moved in the right direction");
      if (ex >= 2) begin
        chk(last_period, 5 + (rt + 1) * 8, "R6 pulse spacing");
        chk(last_width, 4, "R6 pulse width");
      end
    end
    rd_reg(2'd0, v); chk(v, 8'h00, "R9 idle status off track zero");

    // R8 writes during busy
    clr_mon();
    wr_reg(2'd3, 8'd2);
    wr_reg(2'd0, 8'h13);
    wr_reg(2'd1, 8'h55);
    wr_reg(2'd2, 8'h77);
    wr_reg(2'd3, 8'h66);
    wr_reg(2'd0, 8'h00);
    wait_idle();
    rd_reg(2'd1, v); chk(v, 2, "R8 track write ignored while busy");
    rd_reg(2'd2, v); chk(v, 8'h2A, "R8 sector write ignored while busy");
    rd_reg(2'd3, v); chk(v, 2, "R8 data write ignored while busy");
    chk(pulses, 10, "R8 command write ignored while busy");
    chk(head_pos, 2, "R8 head not restored");

    // R9 bit 2 reads 0 while busy even at track zero
    wr_reg(2'd3, 8'd0);
    wr_reg(2'd0, 8'h10);
    wait_idle();
    wr_reg(2'd3, 8'd5);
    wr_reg(2'd0, 8'h10);
    rd_reg(2'd0, v); chk(v, 8'h01, "R9 status while busy");
    wait_idle();

    // R10 unknown command
    clr_mon();
    wr_reg(2'd0, 8'h20);
    rd_reg(2'd0, v); chk(v[0], 0, "R10 unknown command not busy");
    repeat (20) @(negedge clk);
    chk(pulses, 0, "R10 unknown command no pulse");

    // R7 restore limit
    clr_mon();
    disc = 1'b1;
    wr_reg(2'd0, 8'h00);
    wait_idle();
    chk(pulses, 255, "R7 restore pulse limit");
    rd_reg(2'd0, v); chk(v, 8'h10, "R7 seek error status");
    rd_reg(2'd1, v); chk(v, 5, "R7 track unchanged on error");
    disc = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(2'd0, 8'h00);
    wait_idle();
    rd_reg(2'd0, v); chk(v, 8'h04, "R7 error cleared by next command");
    rd_reg(2'd1, v); chk(v, 0, "R3 track cleared after recovery");

    summary();
  end
endmodule